// File: doc/BRIEF.md
# CPU Sleep and Wake Controller

This block holds the processor in a low-power sleep state after software writes a dedicated sleep address. While asleep, the processor run enable is low and the processor's bus request is withdrawn, so a coprocessor is free to own the bus. Two sources end the sleep, and each one resumes the processor differently.

The first source is any interrupt line that is both pending and enabled in the peripheral mask. It wakes the processor even when interrupts are masked inside the processor, and it raises a one-cycle pulse that asks for normal interrupt vectoring. The second source is a wake request from the coprocessor. This request is held in a sticky latch until software writes a separate acknowledge address. It resumes the processor where it stopped, but only once the coprocessor has released the bus.

Because the latch holds the request, a coprocessor wake that arrives together with an interrupt is not lost. The latch also refuses any further sleep until software acknowledges the request. All ports are plain control and status signals with no valid/ready flow. Register writes are single-cycle strobes and need no back-pressure.

Top module: `cpu_sleep_ctrl`

## Requirements
- R1: After reset, cpu_run and cpu_bus_req are 1, and wake_src and irq_resume are 0.
- R2: A write to address SLEEP_ADDR (default 8'h91) with no wake condition pending drives cpu_run and cpu_bus_req to 0 from the next clock edge.
- R3: Writes to any address other than SLEEP_ADDR and ACK_ADDR change neither the run state nor the latched coprocessor request.
- R4: While asleep, a pending interrupt bit whose enable bit is 1 wakes the processor at the next edge and sets wake_src to 0. A pending bit whose enable bit is 0 does not wake it.
- R5: While asleep, a latched coprocessor wake with cop_bus_busy low wakes the processor at the next edge, sets wake_src to 1 and leaves irq_resume at 0.
- R6: While cop_bus_busy is 1, a coprocessor wake does not end sleep.
- R7: With no enabled pending interrupt and no usable coprocessor wake, the processor stays asleep for any number of cycles.
- R8: A sleep write is ignored, and cpu_run stays 1, when an enabled interrupt is pending or a coprocessor wake is pending or latched.
- R9: A coprocessor wake request stays latched until a write to ACK_ADDR (default 8'h92). When a request and an acknowledge arrive in the same cycle, the request is kept.
- R10: When an enabled interrupt and a coprocessor wake are both present while asleep, the interrupt wins (wake_src 0) and the coprocessor request remains latched.
- R11: irq_resume is a pulse exactly one cycle long, raised only by an interrupt wake.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| irq_pending | input | NUM_IRQ | Peripheral interrupt pending bits |
| irq_enable | input | NUM_IRQ | Peripheral interrupt enable mask |
| cop_wake_req | input | 1 | Coprocessor wake request |
| cop_bus_busy | input | 1 | Coprocessor currently owns the bus |
| cpu_run | output | 1 | Processor clock/ready enable |
| cpu_bus_req | output | 1 | Processor bus request |
| wake_src | output | 1 | Cause of the last wake: 0 interrupt, 1 coprocessor |
| irq_resume | output | 1 | One-cycle request for interrupt vectoring after an interrupt wake |

## Verification
If the sleep state is wrong, it shows within one edge as cpu_run and cpu_bus_req holding the wrong level after a sleep write or a wake condition. If the coprocessor latch is wrong, its effect can be hidden until the next sleep write. The bench therefore makes that latch visible at the ports by attempting a sleep right after a coprocessor wake, an acknowledge, or a collision, and then reading cpu_run one edge later. A wrong wake priority shows as wake_src and irq_resume taking the wrong values in the first cycle after the wake.

// File: rtl/cpu_sleep_pkg.sv
package cpu_sleep_pkg;
  typedef enum logic {
    ST_RUN   = 1'b0,
    ST_SLEEP = 1'b1
  } slp_state_e;

  typedef enum logic {
    SRC_IRQ = 1'b0,
    SRC_COP = 1'b1
  } wake_src_e;
endpackage

// File: rtl/irq_detect.sv
module irq_detect #(
  parameter int NUM_IRQ = 8
) (
  input  logic [NUM_IRQ-1:0] pending_i,
  input  logic [NUM_IRQ-1:0] enable_i,
  output logic               hit_o
);
  logic [NUM_IRQ-1:0] live;

  // One gate per interrupt line: a line counts only when its mask bit is set.
  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_line
    assign live[g] = pending_i[g] & enable_i[g];
  end

  assign hit_o = |live;
endmodule

// File: rtl/wake_latch.sv
module wake_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic held_o
);
  logic held_q;

  // A set arriving together with a clear wins, so a request is never lost.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= 1'b0;
    else        held_q <= set_i | (held_q & ~clr_i);
  end

  assign held_o = held_q;

  // R9
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (held_q && !clr_i) |=> held_q);
  // R9
  latch_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> held_q);
endmodule

// File: rtl/sleep_fsm.sv
module sleep_fsm
  import cpu_sleep_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_wr_i,
  input  logic irq_hit_i,
  input  logic cop_pend_i,
  input  logic cop_bus_busy_i,
  output logic cpu_run_o,
  output logic cpu_bus_req_o,
  output logic wake_src_o,
  output logic irq_resume_o
);
  slp_state_e state_q, state_d;
  wake_src_e  src_q, src_d;
  logic       resume_q, resume_d;
  logic       cop_ready;

  // A coprocessor wake is usable only after the coprocessor gives the bus back.
  assign cop_ready = cop_pend_i & ~cop_bus_busy_i;

  always_comb begin
    state_d  = state_q;
    src_d    = src_q;
    resume_d = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (sleep_wr_i && !irq_hit_i && !cop_pend_i) state_d = ST_SLEEP;
      end
      ST_SLEEP: begin
        if (irq_hit_i) begin
          state_d  = ST_RUN;
          src_d    = SRC_IRQ;
          resume_d = 1'b1;
        end else if (cop_ready) begin
          state_d = ST_RUN;
          src_d   = SRC_COP;
        end
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_RUN;
      src_q    <= SRC_IRQ;
      resume_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      src_q    <= src_d;
      resume_q <= resume_d;
    end
  end

  assign cpu_run_o     = (state_q == ST_RUN);
  assign cpu_bus_req_o = (state_q == ST_RUN);
  assign wake_src_o    = src_q;
  assign irq_resume_o  = resume_q;

  // R2
  sleep_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && sleep_wr_i && !irq_hit_i && !cop_pend_i) |=> !cpu_run_o && !cpu_bus_req_o);
  // R8
  sleep_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && (irq_hit_i || cop_pend_i)) |=> cpu_run_o);
  // R7
  stay_asleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SLEEP && !irq_hit_i && !cop_ready) |=> !cpu_run_o);
  // R4
  irq_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SLEEP && irq_hit_i) |=> cpu_run_o && !wake_src_o && irq_resume_o);
  // R5
  cop_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SLEEP && !irq_hit_i && cop_ready) |=> cpu_run_o && wake_src_o && !irq_resume_o);
  // R11
  resume_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_resume_o |=> !irq_resume_o);
endmodule

// File: rtl/cpu_sleep_ctrl.sv
module cpu_sleep_ctrl #(
  parameter int          NUM_IRQ    = 8,
  parameter int          ADDR_W     = 8,
  parameter logic [7:0]  SLEEP_ADDR = 8'h91,
  parameter logic [7:0]  ACK_ADDR   = 8'h92
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [NUM_IRQ-1:0] irq_pending,
  input  logic [NUM_IRQ-1:0] irq_enable,
  input  logic               cop_wake_req,
  input  logic               cop_bus_busy,
  output logic               cpu_run,
  output logic               cpu_bus_req,
  output logic               wake_src,
  output logic               irq_resume
);
  localparam logic [ADDR_W-1:0] SLP_A = ADDR_W'(SLEEP_ADDR);
  localparam logic [ADDR_W-1:0] ACK_A = ADDR_W'(ACK_ADDR);

  logic sleep_wr, ack_wr, irq_hit, cop_held, cop_pend;

  assign sleep_wr = wr_en && (wr_addr == SLP_A);
  assign ack_wr   = wr_en && (wr_addr == ACK_A);

  irq_detect #(.NUM_IRQ(NUM_IRQ)) u_irq (
    .pending_i (irq_pending),
    .enable_i  (irq_enable),
    .hit_o     (irq_hit)
  );

  wake_latch u_cop_latch (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (cop_wake_req),
    .clr_i  (ack_wr),
    .held_o (cop_held)
  );

  // A request that is live this cycle counts as pending before it reaches the latch.
  assign cop_pend = cop_held | cop_wake_req;

  sleep_fsm u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .sleep_wr_i     (sleep_wr),
    .irq_hit_i      (irq_hit),
    .cop_pend_i     (cop_pend),
    .cop_bus_busy_i (cop_bus_busy),
    .cpu_run_o      (cpu_run),
    .cpu_bus_req_o  (cpu_bus_req),
    .wake_src_o     (wake_src),
    .irq_resume_o   (irq_resume)
  );
endmodule

// File: tb/test_cpu_sleep_ctrl.sv
module test_cpu_sleep_ctrl;
  localparam int NI = 8;
  localparam logic [7:0] A_SLP = 8'h91;
  localparam logic [7:0] A_ACK = 8'h92;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [NI-1:0] irq_pending = '0;
  logic [NI-1:0] irq_enable = '0;
  logic cop_wake_req = 1'b0;
  logic cop_bus_busy = 1'b0;
  logic cpu_run, cpu_bus_req, wake_src, irq_resume;
  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  cpu_sleep_ctrl i_cpu_sleep_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .irq_pending(irq_pending), .irq_enable(irq_enable),
    .cop_wake_req(cop_wake_req), .cop_bus_busy(cop_bus_busy),
    .cpu_run(cpu_run), .cpu_bus_req(cpu_bus_req),
    .wake_src(wake_src), .irq_resume(irq_resume)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  // Inputs change on the falling edge; the next falling edge sees the result.
  task automatic write_reg(input logic [7:0] a);
    @(negedge clk); wr_en = 1'b1; wr_addr = a;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 run", cpu_run, 1'b1);
    check("R1 busreq", cpu_bus_req, 1'b1);
    check("R1 src", wake_src, 1'b0);
    check("R1 resume", irq_resume, 1'b0);
  endtask

  task automatic t_other_addr;
    write_reg(8'h33);
    write_reg(8'h90);
    check("R3 run", cpu_run, 1'b1);
    check("R3 busreq", cpu_bus_req, 1'b1);
  endtask

  task automatic t_irq_wake;
    write_reg(A_ACK);
    write_reg(A_SLP);
    check("R2 run", cpu_run, 1'b0);
    check("R2 busreq", cpu_bus_req, 1'b0);
    irq_pending = 8'h08; irq_enable = 8'h00;
    idle(3);
    check("R4 masked", cpu_run, 1'b0);
    irq_pending = 8'h00;
    idle(20);
    check("R7 asleep", cpu_run, 1'b0);
    irq_pending = 8'h08; irq_enable = 8'h08;
    @(negedge clk);
    check("R4 woke", cpu_run, 1'b1);
    check("R4 src", wake_src, 1'b0);
    check("R11 pulse", irq_resume, 1'b1);
    irq_pending = 8'h00;
    @(negedge clk);
    check("R11 one cycle", irq_resume, 1'b0);
  endtask

  task automatic t_refuse_irq;
    irq_pending = 8'h01; irq_enable = 8'h01;
    write_reg(A_SLP);
    check("R8 irq", cpu_run, 1'b1);
    irq_pending = 8'h00;
  endtask

  task automatic t_cop_wake;
    write_reg(A_SLP);
    check("R2 cop asleep", cpu_run, 1'b0);
    cop_bus_busy = 1'b1;
    @(negedge clk); cop_wake_req = 1'b1;
    @(negedge clk); cop_wake_req = 1'b0;
    idle(5);
    check("R6 busy", cpu_run, 1'b0);
    cop_bus_busy = 1'b0;
    @(negedge clk);
    check("R5 woke", cpu_run, 1'b1);
    check("R5 src", wake_src, 1'b1);
    check("R5 no resume", irq_resume, 1'b0);
    write_reg(A_SLP);
    check("R9 held refuse", cpu_run, 1'b1);
    write_reg(A_ACK);
    write_reg(A_SLP);
    check("R9 ack clears", cpu_run, 1'b0);
    irq_pending = 8'h02; irq_enable = 8'h02;
    @(negedge clk);
    check("R4 rewake", wake_src, 1'b0);
    irq_pending = 8'h00;
  endtask

  task automatic t_both;
    write_reg(A_SLP);
    irq_pending = 8'h80; irq_enable = 8'h80; cop_wake_req = 1'b1;
    @(negedge clk);
    check("R10 run", cpu_run, 1'b1);
    check("R10 src", wake_src, 1'b0);
    irq_pending = 8'h00; cop_wake_req = 1'b0;
    write_reg(A_SLP);
    check("R10 kept", cpu_run, 1'b1);
    write_reg(A_ACK);
  endtask

  task automatic t_collide;
    @(negedge clk);
    cop_wake_req = 1'b1; wr_en = 1'b1; wr_addr = A_ACK;
    @(negedge clk);
    cop_wake_req = 1'b0; wr_en = 1'b0;
    write_reg(A_SLP);
    check("R9 collide", cpu_run, 1'b1);
    write_reg(A_ACK);
    write_reg(A_SLP);
    check("R9 after ack", cpu_run, 1'b0);
    irq_pending = 8'h01; irq_enable = 8'h01;
    @(negedge clk);
    irq_pending = 8'h00;
  endtask

  initial begin
    idle(2);
    @(negedge clk) rst_n = 1'b1;
    t_reset;
    t_other_addr;
    t_irq_wake;
    t_refuse_irq;
    t_cop_wake;
    t_both;
    t_collide;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule